// File: doc/BRIEF.md
# Boolean Pattern Match Interrupt Engine

This block watches eight logical channels, each routed from any one of a bank of general-purpose input pins. It raises an interrupt when a programmable sum-of-products expression over those channels becomes true. Every channel feeds one bit slice of the expression. A slice turns its channel into a literal: a constant one, a level taken true or inverted, a single-cycle edge, or an edge that is held until it is used. Each slice can also carry an endpoint mark. The slices from one endpoint up to and including the next endpoint are ANDed into one product term, and all product terms are ORed into the match interrupt.

A mode bit reuses the same eight channels as plain per-pin interrupts. In that mode, the rising and falling enable bits of each channel set a status flag for that channel. Software clears the flags by writing ones to them. Pin inputs pass through a two-stage synchroniser before any evaluation.

Software programs the block through a simple write port with a combinational read-back. The system's reset tree is assumed to deliver `rst_n` already released in step with `clk`.

Top module: `pme_engine`

## Requirements
- R1: After reset, `match_irq`, `pin_irq` and every register read back as zero. Mode zero is pin-interrupt mode.
- R2: Register addresses are as follows. CTRL = 0: bit 0 selects pattern mode, and bit 1 is a clear strobe that reads back 0. PINSEL = 1: 4-bit field of channel c at bits [4c+3:4c]. SLMODE = 2: 3-bit field of slice c at bits [3c+2:3c]. ENDPT = 3: bit c. RISE_EN = 4. FALL_EN = 5. STATUS = 6. Each register reads back what was last written.
- R3: Each channel takes the pin named by its PINSEL field. A level change on that pin reaches `match_irq` at the third rising clock edge after the change.
- R4: Slice mode encodings for constant and level literals: 0 is always true, 1 is true while the channel is high, and 2 is true while it is low.
- R5: Slice modes 3, 4 and 5 are true for exactly one cycle on a rising, falling, or either edge of the channel.
- R6: Modes 6 and 7 latch a rising or falling edge. The latched literal stays true until a product term containing that slice matches, or until CTRL is written with bit 1 set. The clear strobe wins over a new edge.
- R7: A product term is made of the slices after the previous endpoint, up to and including a slice whose ENDPT bit is 1. Slices after the last endpoint are ignored. With ENDPT = 0, `match_irq` stays low.
- R8: In pattern mode, `match_irq` is the registered OR of all product terms. In pin-interrupt mode, `match_irq` stays low.
- R9: In pin-interrupt mode, a rising edge on channel c with RISE_EN[c] = 1, or a falling edge with FALL_EN[c] = 1, sets STATUS[c]. `pin_irq` equals STATUS. In pattern mode, no status bit is set and `pin_irq` is 0.
- R10: Writing STATUS clears the bits written as one. A bit set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 16 | Asynchronous general-purpose pin inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| match_irq | output | 1 | Pattern match interrupt |
| pin_irq | output | 8 | Per-channel pin interrupt flags |

## Verification
The bench times a level change against the three-edge synchroniser path. A design with a stage too many or too few would raise the interrupt one cycle off. It checks that a plain edge literal gives a one-cycle pulse and that a latched edge survives until its term fires. A design that cleared the latch too early would miss a late partner level. One that never cleared it would keep firing, or would ignore the software clear. Trailing slices with no endpoint, and a term split by endpoints, are driven so that a design which let an unclosed term through would raise a false interrupt. Random configurations and pin traffic then cover the interplay of the clear strobes, the mode switch and the same-cycle set-and-clear of status.

// File: rtl/pme_pkg.sv
package pme_pkg;
  typedef enum logic [2:0] {
    LIT_ONE      = 3'd0,
    LIT_HIGH     = 3'd1,
    LIT_LOW      = 3'd2,
    LIT_RISE     = 3'd3,
    LIT_FALL     = 3'd4,
    LIT_ANY      = 3'd5,
    LIT_HOLD_UP  = 3'd6,
    LIT_HOLD_DN  = 3'd7
  } lit_mode_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_PINSEL = 3'd1;
  localparam logic [2:0] A_SLMODE = 3'd2;
  localparam logic [2:0] A_ENDPT  = 3'd3;
  localparam logic [2:0] A_RISEEN = 3'd4;
  localparam logic [2:0] A_FALLEN = 3'd5;
  localparam logic [2:0] A_STATUS = 3'd6;
endpackage

// File: rtl/pme_sync.sv
module pme_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/pme_chan_sel.sv
module pme_chan_sel #(
  parameter int NUM_PINS = 16,
  parameter int NUM_CH   = 8,
  parameter int SELW     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PINS-1:0]    pins_sync_i,
  input  logic [NUM_CH*SELW-1:0] sel_i,
  output logic [NUM_CH-1:0]      cur_o,
  output logic [NUM_CH-1:0]      rise_o,
  output logic [NUM_CH-1:0]      fall_o
);
  logic [NUM_CH-1:0] cur_w, prev_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_route
    assign cur_w[c] = pins_sync_i[sel_i[c*SELW +: SELW]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_w;
  end

  assign cur_o  = cur_w;
  assign rise_o = cur_w & ~prev_q;
  assign fall_o = ~cur_w & prev_q;
endmodule

// File: rtl/pme_slice_eval.sv
module pme_slice_eval
  import pme_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pm_en_i,
  input  logic                  clr_hold_i,
  input  logic [NUM_CH-1:0]     cur_i,
  input  logic [NUM_CH-1:0]     rise_i,
  input  logic [NUM_CH-1:0]     fall_i,
  input  logic [3*NUM_CH-1:0]   mode_i,
  input  logic [NUM_CH-1:0]     endpt_i,
  output logic [NUM_CH-1:0]     hold_o,
  output logic                  match_o
);
  logic [NUM_CH-1:0] lit, fire, term_hit, hold_q, hold_d;
  logic              match_q, match_d;

  // literal per slice
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      case (lit_mode_e'(mode_i[3*i +: 3]))
        LIT_ONE:     lit[i] = 1'b1;
        LIT_HIGH:    lit[i] = cur_i[i];
        LIT_LOW:     lit[i] = ~cur_i[i];
        LIT_RISE:    lit[i] = rise_i[i];
        LIT_FALL:    lit[i] = fall_i[i];
        LIT_ANY:     lit[i] = rise_i[i] | fall_i[i];
        LIT_HOLD_UP: lit[i] = rise_i[i] | hold_q[i];
        default:     lit[i] = fall_i[i] | hold_q[i];
      endcase
    end
  end

  // running product, closed at each endpoint
  always_comb begin
    logic run, prod;
    run = 1'b1;
    for (int i = 0; i < NUM_CH; i++) begin
      prod    = run & lit[i];
      fire[i] = prod & endpt_i[i];
      run     = endpt_i[i] ? 1'b1 : prod;
    end
  end

  // spread each term's result back onto its member slices
  always_comb begin
    logic hit;
    hit = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (endpt_i[i]) hit = fire[i];
      term_hit[i] = hit;
    end
  end

  always_comb begin
    match_d = pm_en_i & (|fire);
    hold_d  = hold_q;
    if (clr_hold_i) begin
      hold_d = '0;
    end else if (pm_en_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (term_hit[i])
          hold_d[i] = 1'b0;
        else if (mode_i[3*i +: 3] == LIT_HOLD_UP)
          hold_d[i] = hold_q[i] | rise_i[i];
        else if (mode_i[3*i +: 3] == LIT_HOLD_DN)
          hold_d[i] = hold_q[i] | fall_i[i];
        else
          hold_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      match_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      match_q <= match_d;
    end
  end

  assign hold_o  = hold_q;
  assign match_o = match_q;
endmodule

// File: rtl/pme_pin_status.sv
module pme_pin_status #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_en_i,
  input  logic [NUM_CH-1:0] rise_i,
  input  logic [NUM_CH-1:0] fall_i,
  input  logic [NUM_CH-1:0] rise_en_i,
  input  logic [NUM_CH-1:0] fall_en_i,
  input  logic              w1c_we_i,
  input  logic [NUM_CH-1:0] w1c_data_i,
  output logic [NUM_CH-1:0] status_o
);
  logic [NUM_CH-1:0] stat_q, stat_d, set_w, clr_w;

  always_comb begin
    set_w  = pin_en_i ? ((rise_i & rise_en_i) | (fall_i & fall_en_i)) : '0;
    clr_w  = w1c_we_i ? w1c_data_i : '0;
    stat_d = (stat_q & ~clr_w) | set_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status_o = stat_q;
endmodule

// File: rtl/pme_engine.sv
module pme_engine
  import pme_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_CH   = 8,
  parameter int DW       = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  output logic [DW-1:0]       cfg_rdata,
  output logic                match_irq,
  output logic [NUM_CH-1:0]   pin_irq
);
  localparam int SELW = $clog2(NUM_PINS);
  localparam int PSW  = NUM_CH * SELW;
  localparam int MSW  = 3 * NUM_CH;

  logic                mode_q, mode_d;
  logic [PSW-1:0]      pinsel_q, pinsel_d;
  logic [MSW-1:0]      slmode_q, slmode_d;
  logic [NUM_CH-1:0]   endpt_q, endpt_d, ren_q, ren_d, fen_q, fen_d;
  logic                wr_ctrl, wr_psel, wr_slm, wr_endp, wr_ren, wr_fen, wr_stat;
  logic                clr_hold;
  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_CH-1:0]   ch_cur, ch_rise, ch_fall, status_w, hold_w;
  logic                match_w;

  always_comb begin
    wr_ctrl  = cfg_we && (cfg_addr == A_CTRL);
    wr_psel  = cfg_we && (cfg_addr == A_PINSEL);
    wr_slm   = cfg_we && (cfg_addr == A_SLMODE);
    wr_endp  = cfg_we && (cfg_addr == A_ENDPT);
    wr_ren   = cfg_we && (cfg_addr == A_RISEEN);
    wr_fen   = cfg_we && (cfg_addr == A_FALLEN);
    wr_stat  = cfg_we && (cfg_addr == A_STATUS);
    clr_hold = wr_ctrl && cfg_wdata[1];
  end

  always_comb begin
    mode_d   = wr_ctrl ? cfg_wdata[0]          : mode_q;
    pinsel_d = wr_psel ? cfg_wdata[PSW-1:0]    : pinsel_q;
    slmode_d = wr_slm  ? cfg_wdata[MSW-1:0]    : slmode_q;
    endpt_d  = wr_endp ? cfg_wdata[NUM_CH-1:0] : endpt_q;
    ren_d    = wr_ren  ? cfg_wdata[NUM_CH-1:0] : ren_q;
    fen_d    = wr_fen  ? cfg_wdata[NUM_CH-1:0] : fen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      pinsel_q <= '0;
      slmode_q <= '0;
      endpt_q  <= '0;
      ren_q    <= '0;
      fen_q    <= '0;
    end else begin
      mode_q   <= mode_d;
      pinsel_q <= pinsel_d;
      slmode_q <= slmode_d;
      endpt_q  <= endpt_d;
      ren_q    <= ren_d;
      fen_q    <= fen_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTRL:   cfg_rdata[0]          = mode_q;
      A_PINSEL: cfg_rdata[PSW-1:0]    = pinsel_q;
      A_SLMODE: cfg_rdata[MSW-1:0]    = slmode_q;
      A_ENDPT:  cfg_rdata[NUM_CH-1:0] = endpt_q;
      A_RISEEN: cfg_rdata[NUM_CH-1:0] = ren_q;
      A_FALLEN: cfg_rdata[NUM_CH-1:0] = fen_q;
      A_STATUS: cfg_rdata[NUM_CH-1:0] = status_w;
      default:  cfg_rdata             = '0;
    endcase
  end

  pme_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(pins_sync)
  );

  pme_chan_sel #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH), .SELW(SELW)) u_sel (
    .clk(clk), .rst_n(rst_n), .pins_sync_i(pins_sync), .sel_i(pinsel_q),
    .cur_o(ch_cur), .rise_o(ch_rise), .fall_o(ch_fall)
  );

  pme_slice_eval #(.NUM_CH(NUM_CH)) u_eval (
    .clk(clk), .rst_n(rst_n), .pm_en_i(mode_q), .clr_hold_i(clr_hold),
    .cur_i(ch_cur), .rise_i(ch_rise), .fall_i(ch_fall),
    .mode_i(slmode_q), .endpt_i(endpt_q), .hold_o(hold_w), .match_o(match_w)
  );

  pme_pin_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_n), .pin_en_i(~mode_q),
    .rise_i(ch_rise), .fall_i(ch_fall), .rise_en_i(ren_q), .fall_en_i(fen_q),
    .w1c_we_i(wr_stat), .w1c_data_i(cfg_wdata[NUM_CH-1:0]), .status_o(status_w)
  );

  assign match_irq = match_w;
  assign pin_irq   = mode_q ? '0 : status_w;
endmodule

// File: rtl/pme_chk.sv
module pme_chk #(
  parameter int NUM_CH = 8,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_q,
  input logic              cfg_we,
  input logic [2:0]        cfg_addr,
  input logic [DW-1:0]     cfg_wdata,
  input logic [NUM_CH-1:0] endpt_q,
  input logic [NUM_CH-1:0] hold_w,
  input logic [NUM_CH-1:0] status_w,
  input logic              match_irq,
  input logic [NUM_CH-1:0] pin_irq
);
  // R8
  no_match_in_pin_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |=> !match_irq);

  // R9
  no_pin_irq_in_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (pin_irq == '0));

  // R9
  no_status_set_in_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !(cfg_we && cfg_addr == 3'd6)) |=> (status_w == $past(status_w)));

  // R6
  no_hold_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd0 && cfg_wdata[1]) |=> (hold_w == '0));

  // R7
  no_match_without_endpoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (endpt_q == '0) |=> !match_irq);
endmodule

bind pme_engine pme_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .endpt_q(endpt_q),
  .hold_w(hold_w), .status_w(status_w), .match_irq(match_irq), .pin_irq(pin_irq)
);

// File: tb/pme_engine_tb.sv
module pme_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pins;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [31:0]   cfg_wdata;
  wire  [31:0]   cfg_rdata;
  wire           match_irq;
  wire  [NC-1:0] pin_irq;

  int    n_cmp = 0;
  int    n_bad = 0;
  string req_tag = "R1";

  pme_engine u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .match_irq(match_irq), .pin_irq(pin_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit [NP-1:0] m_s1, m_s2;
  bit [NC-1:0] m_prev, m_hold, m_stat, m_endpt, m_ren, m_fen;
  bit          m_irq, m_mode;
  int          m_sel[NC];
  int          m_lm[NC];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit [NC-1:0] cur, r, f, lit, hit;
    bit [NC-1:0] w1c;
    bit any;
    int members[$];
    for (int c = 0; c < NC; c++) cur[c] = m_s2[m_sel[c]];
    r = cur & ~m_prev;
    f = ~cur & m_prev;
    for (int c = 0; c < NC; c++) begin
      case (m_lm[c])
        0: lit[c] = 1'b1;
        1: lit[c] = cur[c];
        2: lit[c] = !cur[c];
        3: lit[c] = r[c];
        4: lit[c] = f[c];
        5: lit[c] = r[c] | f[c];
        6: lit[c] = r[c] | m_hold[c];
        default: lit[c] = f[c] | m_hold[c];
      endcase
    end
    hit = '0; any = 1'b0;
    for (int c = 0; c < NC; c++) begin
      members.push_back(c);
      if (m_endpt[c]) begin
        bit all;
        all = 1'b1;
        foreach (members[k]) all &= lit[members[k]];
        if (all) begin
          any = 1'b1;
          foreach (members[k]) hit[members[k]] = 1'b1;
        end
        members.delete();
      end
    end
    if (cfg_we && cfg_addr == 3'd0 && cfg_wdata[1]) m_hold = '0;
    else if (m_mode)
      for (int c = 0; c < NC; c++) begin
        if (m_lm[c] < 6 || hit[c]) m_hold[c] = 1'b0;
        else if ((m_lm[c] == 6 && r[c]) || (m_lm[c] == 7 && f[c])) m_hold[c] = 1'b1;
      end
    w1c = (cfg_we && cfg_addr == 3'd6) ? cfg_wdata[NC-1:0] : '0;
    m_stat = m_stat & ~w1c;
    if (!m_mode) m_stat |= (r & m_ren) | (f & m_fen);
    m_irq = m_mode & any;
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: m_mode = cfg_wdata[0];
        3'd1: for (int c = 0; c < NC; c++) m_sel[c] = int'(cfg_wdata[4*c +: 4]);
        3'd2: for (int c = 0; c < NC; c++) m_lm[c] = int'(cfg_wdata[3*c +: 3]);
        3'd3: m_endpt = cfg_wdata[NC-1:0];
        3'd4: m_ren = cfg_wdata[NC-1:0];
        3'd5: m_fen = cfg_wdata[NC-1:0];
        default: ;
      endcase
    end
    m_prev = cur;
    m_s2 = m_s1;
    m_s1 = pins;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_hold = '0; m_stat = '0;
      m_endpt = '0; m_ren = '0; m_fen = '0; m_irq = 1'b0; m_mode = 1'b0;
      for (int c = 0; c < NC; c++) begin m_sel[c] = 0; m_lm[c] = 0; end
    end else begin
      model_step();
    end
  end

  // cycle-by-cycle comparison against the reference (R8 match, R9 pin flags)
  always @(negedge clk) begin
    check({req_tag, " R8 match_irq"}, {31'b0, match_irq}, {31'b0, m_irq});
    check({req_tag, " R9 pin_irq"}, {24'b0, pin_irq}, {24'b0, (m_mode ? 8'h00 : m_stat)});
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd_check(string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(tag, cfg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] modes(int m0, int m1, int m2, int m3,
                                        int m4, int m5, int m6, int m7);
    return {8'h00, 3'(m7), 3'(m6), 3'(m5), 3'(m4), 3'(m3), 3'(m2), 3'(m1), 3'(m0)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 1'b0; pins = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    req_tag = "R1";
    check("R1 match_irq reset", {31'b0, match_irq}, 32'd0);
    check("R1 pin_irq reset", {24'b0, pin_irq}, 32'd0);
    rst_n = 1'b1;
    rd_check("R1 STATUS reset", 3'd6, 32'd0);
    rd_check("R1 PINSEL reset", 3'd1, 32'd0);

    req_tag = "R2";
    wr(3'd1, 32'h7654_3210);
    rd_check("R2 PINSEL readback", 3'd1, 32'h7654_3210);
    wr(3'd2, modes(1,2,1,1,0,0,0,0));
    rd_check("R2 SLMODE readback", 3'd2, {8'h0, modes(1,2,1,1,0,0,0,0)[23:0]});
    wr(3'd3, 32'h0A);
    rd_check("R2 ENDPT readback", 3'd3, 32'h0A);
    wr(3'd0, 32'h3);
    rd_check("R2 CTRL strobe reads 0", 3'd0, 32'h1);

    // term IN0&~IN1, term IN2&IN3, slices 4..7 constant but unclosed (R4, R7)
    req_tag = "R3";
    idle(4);
    pins = 16'h0001;
    @(negedge clk); @(negedge clk);
    check("R3 not yet at second edge", {31'b0, match_irq}, 32'd0);
    @(negedge clk);
    check("R3 level seen at third edge", {31'b0, match_irq}, 32'd1);
    req_tag = "R4";
    pins = 16'h0003; idle(4);
    check("R4 inverted literal blocks", {31'b0, match_irq}, 32'd0);
    pins = 16'h000E; idle(4);
    check("R8 second term ORed", {31'b0, match_irq}, 32'd1);
    req_tag = "R7";
    pins = 16'h0000; idle(4);
    check("R7 unclosed trailing slices ignored", {31'b0, match_irq}, 32'd0);
    wr(3'd2, modes(0,0,0,0,0,0,0,0));
    wr(3'd3, 32'h00);
    idle(4);
    check("R7 no endpoint no match", {31'b0, match_irq}, 32'd0);
    wr(3'd3, 32'h80);
    idle(2);
    check("R7 single closing endpoint", {31'b0, match_irq}, 32'd1);

    // R5: single-cycle edge pulse
    req_tag = "R5";
    wr(3'd2, modes(3,0,0,0,0,0,0,0));
    wr(3'd3, 32'h01);
    idle(4);
    pins = 16'h0001;
    cnt = 0;
    repeat (8) begin @(negedge clk); if (match_irq) cnt++; end
    check("R5 rise pulse width", cnt, 1);

    // R6: held edge
    req_tag = "R6";
    pins = 16'h0000;
    wr(3'd2, modes(6,1,0,0,0,0,0,0));
    wr(3'd3, 32'h02);
    idle(4);
    pins = 16'h0001; idle(5);
    check("R6 held edge waits for partner", {31'b0, match_irq}, 32'd0);
    pins = 16'h0003;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R6 held edge fires", {31'b0, match_irq}, 32'd1);
    @(negedge clk);
    check("R6 hold consumed by match", {31'b0, match_irq}, 32'd0);
    pins = 16'h0000; idle(4);
    pins = 16'h0001; idle(5);
    wr(3'd0, 32'h3);
    pins = 16'h0003;
    cnt = 0;
    repeat (6) begin @(negedge clk); if (match_irq) cnt++; end
    check("R6 software clear drops hold", cnt, 0);

    // R3 remap: channel 0 from pin 9
    req_tag = "R3";
    pins = 16'h0000;
    wr(3'd1, 32'h7654_3219);
    wr(3'd2, modes(1,0,0,0,0,0,0,0));
    wr(3'd3, 32'h01);
    idle(4);
    pins = 16'h0001; idle(4);
    check("R3 unselected pin ignored", {31'b0, match_irq}, 32'd0);
    pins = 16'h0200; idle(4);
    check("R3 selected pin 9 matches", {31'b0, match_irq}, 32'd1);

    // R9, R10 pin interrupt mode
    req_tag = "R9";
    pins = 16'h0000;
    wr(3'd1, 32'h7654_3210);
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h01);
    wr(3'd5, 32'h02);
    idle(4);
    wr(3'd6, 32'hFF);
    pins = 16'h0003;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R9 rise enable sets flag", {24'b0, pin_irq}, 32'h01);
    pins = 16'h0000; idle(4);
    check("R9 fall enable sets flag", {24'b0, pin_irq}, 32'h03);
    req_tag = "R10";
    wr(3'd6, 32'h01);
    rd_check("R10 write one clears", 3'd6, 32'h02);
    wr(3'd0, 32'h1);
    pins = 16'h0003; idle(4);
    rd_check("R9 no set in pattern mode", 3'd6, 32'h02);
    check("R9 pin_irq quiet in pattern mode", {24'b0, pin_irq}, 32'd0);

    // random configurations and traffic, compared every cycle
    req_tag = "R8/R9 random";
    for (int round = 0; round < 60; round++) begin
      wr(3'd1, $urandom);
      wr(3'd2, $urandom);
      wr(3'd3, $urandom);
      wr(3'd4, $urandom);
      wr(3'd5, $urandom);
      wr(3'd0, {30'b0, 1'b0, 1'($urandom)});
      for (int cyc = 0; cyc < 300; cyc++) begin
        @(negedge clk);
        pins = pins ^ (16'(1) << ($urandom % 32));
        if ($urandom % 25 == 0) begin
          cfg_we = 1'b1;
          cfg_addr = ($urandom % 2 == 0) ? 3'd6 : 3'd0;
          cfg_wdata = (cfg_addr == 3'd0) ? {30'b0, 1'b1, m_mode} : $urandom;
        end else begin
          cfg_we = 1'b0;
        end
      end
      @(negedge clk);
      cfg_we = 1'b0;
    end

    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule